// File: doc/BRIEF.md
# Synchronous Character Sync Hunter

This block sits behind the serial-to-parallel front end of a synchronous receiver. It accepts one data bit each time the receive bit enable is high. It then looks for character alignment in one of two ways. In internal mode it slides a window over the incoming bits and compares that window with a programmed sync pattern after every bit. In external mode it waits for a rising edge on a sync strobe driven by other logic.

Once alignment is found, the block raises a sync-detect flag and begins framing. It cuts the following bits into characters of the programmed length and presents each character with a one-cycle strobe. Sync can require one pattern, or two consecutive patterns. Software can clear the detect flag with a status read. A hunt command drops alignment and starts the search again.

Top module: `sync_hunter`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), sync_det, char_valid and char_data are all zero, and the block is hunting.
- R2: Character length is 5 + len_sel bits (len_sel 0..3 gives 5..8 bits). Bits arrive least significant first. Each character appears in char_data right-aligned, with the bits above the length set to zero.
- R3: In internal single-sync mode (ext_mode=0, dual_sync=0), the last len bits are compared with sync_char1 after every accepted bit. On a match, sync_det is high after the clock edge that accepted the matching bit, and framing starts with the next bit.
- R4: With dual_sync=1, a sync_char1 match is followed by exactly one character. That character must equal sync_char2 before sync_det rises. If it does not, the block goes back to bit-by-bit hunting and sync_det stays low.
- R5: While aligned, every len-th accepted bit produces a one-cycle char_valid pulse after the clock edge that accepted that bit, and char_data holds the character.
- R6: With ext_mode=1, rx_data never causes alignment. A 0-to-1 transition on ext_sync_in sets sync_det at the next clock edge. Framing counts only bits accepted after that edge. An ext_sync_in level that stays high does not restart framing.
- R7: A status_rd pulse clears sync_det at the next clock edge. Framing of characters continues.
- R8: A hunt_cmd pulse clears sync_det and stops framing at the next clock edge. It takes priority over every other event in that cycle. No char_valid appears until alignment is found again.
- R9: Once aligned, sync patterns are not looked for. A character equal to sync_char1 is delivered as ordinary data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit_en | input | 1 | High for one cycle per received bit |
| rx_data | input | 1 | Received serial bit, valid with rx_bit_en |
| len_sel | input | 2 | Character length minus five |
| dual_sync | input | 1 | 1: two sync characters required |
| ext_mode | input | 1 | 1: alignment from ext_sync_in |
| sync_char1 | input | 8 | First (or only) sync pattern, right-aligned |
| sync_char2 | input | 8 | Second sync pattern, right-aligned |
| ext_sync_in | input | 1 | External alignment strobe, rising edge active |
| hunt_cmd | input | 1 | Pulse: drop alignment and hunt again |
| status_rd | input | 1 | Pulse: clear sync_det |
| sync_det | output | 1 | Alignment achieved flag |
| char_data | output | 8 | Last framed character |
| char_valid | output | 1 | One-cycle strobe for char_data |

## Verification
All results are one register stage away from their cause. sync_det and char_valid/char_data change at the same clock edge that accepts the completing bit, or that sees the hunt, status-read or external strobe. The bench drives each stimulus on a falling edge, leaves one rising edge to pass, and samples on the next falling edge. This means every check lands in the first cycle the result is due, which is also the only cycle a char_valid pulse exists. Bits are sent with an idle cycle between them. A strobe that came out one cycle early or late would therefore be seen as a wrong value, not missed.

// File: rtl/sync_hunter_pkg.sv
// Package: shared types of the sync hunter.
// Assumes: used by every module under sync_hunter.
package sync_hunter_pkg;

    // Alignment phase of the receiver
    typedef enum logic [1:0] {
        PH_HUNT   = 2'd0,
        PH_SECOND = 2'd1,
        PH_LOCKED = 2'd2
    } phase_t;

endpackage

// File: rtl/sh_window.sv
// Module: sh_window
// Shifts accepted bits (LSB first) into a window register. It presents the
// window that results from the current bit, right-aligned to the active
// character length, and compares that window with each sync pattern.
// Assumes: len lies in MIN_W..MAX_W.
module sh_window #(
    parameter int MAX_W  = 8,
    parameter int N_PAT  = 2,
    parameter int LEN_W  = $clog2(MAX_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_en,
    input  logic                    bit_in,
    input  logic [LEN_W-1:0]        len,
    input  logic [MAX_W-1:0]        pat [N_PAT],
    output logic [MAX_W-1:0]        win_next,
    output logic [N_PAT-1:0]        pat_hit
);
    logic [MAX_W-1:0] win_q;
    logic [MAX_W-1:0] shifted;
    logic [MAX_W-1:0] len_mask;
    logic [LEN_W-1:0] drop;

    // Window after the current bit, newest bit at the top
    always_comb begin
        shifted  = {bit_in, win_q[MAX_W-1:1]};
        drop     = LEN_W'(MAX_W) - len;
        win_next = shifted >> drop;
        len_mask = {MAX_W{1'b1}} >> drop;
    end

    // Window register, moves once per accepted bit
    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else if (bit_en) win_q <= shifted;
    end

    // One comparator per sync pattern
    for (genvar g = 0; g < N_PAT; g++) begin : g_cmp
        assign pat_hit[g] = (win_next == (pat[g] & len_mask));
    end

    AST_WIN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_next & ~len_mask) == '0); // R2
endmodule

// File: rtl/sh_edge.sv
// Module: sh_edge
// Registers the external sync strobe and flags its 0-to-1 transition.
// Assumes: ext_sync_in is already synchronous to clk.
module sh_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    logic prev_q;

    // Previous level of the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else prev_q <= level_in;
    end

    assign rise = level_in & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R6
endmodule

// File: rtl/sh_framer.sv
// Module: sh_framer
// Sequences hunt, second-pattern and locked phases. It owns the sync flag
// and counts bits into characters once locked.
// Assumes: pat_hit and win_next belong to the bit offered this cycle.
module sh_framer
    import sync_hunter_pkg::*;
#(
    parameter int MAX_W = 8,
    parameter int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [LEN_W-1:0]  len,
    input  logic              dual_sync,
    input  logic              ext_mode,
    input  logic              ext_rise,
    input  logic              hunt_cmd,
    input  logic              status_rd,
    input  logic [1:0]        pat_hit,
    input  logic [MAX_W-1:0]  win_next,
    output logic              sync_det,
    output logic              char_valid,
    output logic [MAX_W-1:0]  char_data
);
    phase_t           phase_q;
    logic [LEN_W-1:0] cnt_q;
    logic             last_bit;

    assign last_bit = (cnt_q == len - LEN_W'(1));

    // Phase, bit counter, sync flag and character output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_HUNT;
            cnt_q      <= '0;
            sync_det   <= 1'b0;
            char_valid <= 1'b0;
            char_data  <= '0;
        end else begin
            char_valid <= 1'b0;
            if (hunt_cmd) begin
                phase_q  <= PH_HUNT;
                cnt_q    <= '0;
                sync_det <= 1'b0;
            end else begin
                if (status_rd) sync_det <= 1'b0;
                unique case (phase_q)
                    PH_HUNT: begin
                        cnt_q <= '0;
                        if (ext_mode) begin
                            if (ext_rise) begin
                                phase_q  <= PH_LOCKED;
                                sync_det <= 1'b1;
                            end
                        end else if (bit_en && pat_hit[0]) begin
                            if (dual_sync) phase_q <= PH_SECOND;
                            else begin
                                phase_q  <= PH_LOCKED;
                                sync_det <= 1'b1;
                            end
                        end
                    end
                    PH_SECOND: begin
                        if (bit_en) begin
                            if (last_bit) begin
                                cnt_q <= '0;
                                if (pat_hit[1]) begin
                                    phase_q  <= PH_LOCKED;
                                    sync_det <= 1'b1;
                                end else begin
                                    phase_q <= PH_HUNT;
                                end
                            end else begin
                                cnt_q <= cnt_q + LEN_W'(1);
                            end
                        end
                    end
                    PH_LOCKED: begin
                        if (bit_en) begin
                            if (last_bit) begin
                                cnt_q      <= '0;
                                char_valid <= 1'b1;
                                char_data  <= win_next;
                            end else begin
                                cnt_q <= cnt_q + LEN_W'(1);
                            end
                        end
                    end
                    default: phase_q <= PH_HUNT;
                endcase
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid); // R5
    AST_VALID_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> $past(bit_en)); // R5
    AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_cmd |=> (!sync_det && !char_valid)); // R8
    AST_SYNC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_det) |-> $past(bit_en || ext_rise)); // R3
    AST_CNT_IN_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < len); // R2
endmodule

// File: rtl/sync_hunter.sv
// Module: sync_hunter (top)
// Hunts for one or two sync characters, or takes an external strobe, then
// frames the bit stream into characters of a programmable length.
// Assumes: one bit per rx_bit_en pulse, and at least one idle cycle
// is not required between bits.
module sync_hunter #(
    parameter int MAX_W   = 8,
    parameter int MIN_W   = 5,
    parameter int SEL_W   = $clog2(MAX_W - MIN_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit_en,
    input  logic             rx_data,
    input  logic [SEL_W-1:0] len_sel,
    input  logic             dual_sync,
    input  logic             ext_mode,
    input  logic [MAX_W-1:0] sync_char1,
    input  logic [MAX_W-1:0] sync_char2,
    input  logic             ext_sync_in,
    input  logic             hunt_cmd,
    input  logic             status_rd,
    output logic             sync_det,
    output logic [MAX_W-1:0] char_data,
    output logic             char_valid
);
    localparam int LEN_W = $clog2(MAX_W + 1);
    localparam int N_PAT = 2;

    logic [LEN_W-1:0] len;
    logic [MAX_W-1:0] pats [N_PAT];
    logic [MAX_W-1:0] win_next;
    logic [N_PAT-1:0] pat_hit;
    logic             ext_rise;

    // Active character length and pattern list
    always_comb begin
        len     = LEN_W'(MIN_W) + LEN_W'(len_sel);
        pats[0] = sync_char1;
        pats[1] = sync_char2;
    end

    sh_window #(.MAX_W(MAX_W), .N_PAT(N_PAT), .LEN_W(LEN_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (rx_bit_en),
        .bit_in   (rx_data),
        .len      (len),
        .pat      (pats),
        .win_next (win_next),
        .pat_hit  (pat_hit)
    );

    sh_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (ext_sync_in),
        .rise     (ext_rise)
    );

    sh_framer #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (rx_bit_en),
        .len        (len),
        .dual_sync  (dual_sync),
        .ext_mode   (ext_mode),
        .ext_rise   (ext_rise),
        .hunt_cmd   (hunt_cmd),
        .status_rd  (status_rd),
        .pat_hit    (pat_hit),
        .win_next   (win_next),
        .sync_det   (sync_det),
        .char_valid (char_valid),
        .char_data  (char_data)
    );

    AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !rx_bit_en && !ext_sync_in) |=> !sync_det); // R7
endmodule

// File: tb/sync_hunter_tb.sv
`timescale 1ns/1ps
module sync_hunter_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_bit_en, rx_data;
    logic [1:0] len_sel;
    logic       dual_sync, ext_mode;
    logic [7:0] sync_char1, sync_char2;
    logic       ext_sync_in, hunt_cmd, status_rd;
    logic       sync_det, char_valid;
    logic [7:0] char_data;

    int checks = 0;
    int errors = 0;
    bit early_v;
    bit done = 0;

    always #2.5 clk = ~clk;

    sync_hunter u_dut (
        .clk(clk), .rst_n(rst_n), .rx_bit_en(rx_bit_en), .rx_data(rx_data),
        .len_sel(len_sel), .dual_sync(dual_sync), .ext_mode(ext_mode),
        .sync_char1(sync_char1), .sync_char2(sync_char2),
        .ext_sync_in(ext_sync_in), .hunt_cmd(hunt_cmd), .status_rd(status_rd),
        .sync_det(sync_det), .char_data(char_data), .char_valid(char_valid)
    );

    // {len_sel, dual, sync1, sync2, data}; sync1 is odd so no partial match
    localparam logic [26:0] VEC [0:4] = '{
        {2'd3, 1'b0, 8'h69, 8'h00, 8'hA5},
        {2'd0, 1'b0, 8'h15, 8'h00, 8'h0B},
        {2'd1, 1'b1, 8'h2B, 8'h1C, 8'h33},
        {2'd2, 1'b1, 8'h4F, 8'h52, 8'h7E},
        {2'd3, 1'b1, 8'h69, 8'h96, 8'h3C}
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Drive one bit, let one edge pass, sample at the following falling edge
    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_data = b; rx_bit_en = 1'b1;
        @(negedge clk);
        rx_bit_en = 1'b0;
    endtask

    // Send len bits LSB first; note any char_valid before the last bit
    task automatic send_char(input logic [7:0] v, input int len);
        early_v = 0;
        for (int i = 0; i < len; i++) begin
            send_bit(v[i]);
            if (i < len - 1 && char_valid) early_v = 1;
        end
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        rst_n = 1'b0; rx_bit_en = 0; rx_data = 0; len_sel = 2'd3;
        dual_sync = 0; ext_mode = 0; sync_char1 = 8'h69; sync_char2 = 8'h96;
        ext_sync_in = 0; hunt_cmd = 0; status_rd = 0;
        do_reset();
        // R1: reset state
        chk({7'd0, sync_det}, 8'd0, "R1 sync_det");
        chk({7'd0, char_valid}, 8'd0, "R1 char_valid");
        chk(char_data, 8'd0, "R1 char_data");

        // Vector walk: R2 R3 R4 R5 across lengths and sync counts
        foreach (VEC[k]) begin
            int len;
            {len_sel, dual_sync, sync_char1, sync_char2} = VEC[k][26:8];
            len = 5 + int'(len_sel);
            do_reset();
            send_char(sync_char1, len);
            chk({7'd0, sync_det}, {7'd0, !dual_sync}, "R3 sync after first pattern");
            if (dual_sync) begin
                send_char(sync_char2, len);
                chk({7'd0, sync_det}, 8'd1, "R4 sync after second pattern");
            end
            send_char(VEC[k][7:0], len);
            chk({7'd0, char_valid}, 8'd1, "R5 strobe on last bit");
            chk({7'd0, early_v}, 8'd0, "R5 no early strobe");
            chk(char_data, VEC[k][7:0], "R2 character value");
        end

        // R4: wrong second character returns to hunting
        len_sel = 2'd3; dual_sync = 1; sync_char1 = 8'h69; sync_char2 = 8'h96;
        do_reset();
        send_char(8'h69, 8);
        send_char(8'h00, 8);
        chk({7'd0, sync_det}, 8'd0, "R4 mismatch keeps sync low");
        chk({7'd0, char_valid}, 8'd0, "R4 mismatch gives no strobe");
        send_char(8'h69, 8);
        send_char(8'h96, 8);
        chk({7'd0, sync_det}, 8'd1, "R4 retry locks");

        // R7: status read clears flag, framing continues
        pulse(status_rd);
        chk({7'd0, sync_det}, 8'd0, "R7 flag cleared");
        send_char(8'hC3, 8);
        chk({7'd0, char_valid}, 8'd1, "R7 framing continues");
        chk(char_data, 8'hC3, "R7 character value");

        // R9: sync pattern after lock is plain data
        send_char(8'h69, 8);
        chk({7'd0, char_valid}, 8'd1, "R9 pattern delivered");
        chk(char_data, 8'h69, "R9 pattern value");
        chk({7'd0, sync_det}, 8'd0, "R9 flag untouched");

        // R8: hunt command stops framing
        status_rd = 0;
        do_reset(); dual_sync = 0;
        send_char(8'h69, 8);
        pulse(hunt_cmd);
        chk({7'd0, sync_det}, 8'd0, "R8 flag cleared");
        send_char(8'h5A, 8);
        chk({7'd0, char_valid | early_v}, 8'd0, "R8 no strobe while hunting");

        // R6: external strobe mode
        ext_mode = 1; len_sel = 2'd3;
        do_reset();
        send_char(8'h69, 8);
        chk({7'd0, sync_det}, 8'd0, "R6 data ignored while hunting");
        @(negedge clk); ext_sync_in = 1'b1;
        @(negedge clk);
        chk({7'd0, sync_det}, 8'd1, "R6 sync on rising strobe");
        send_char(8'hC3, 8);
        chk({7'd0, char_valid}, 8'd1, "R6 first framed strobe");
        chk(char_data, 8'hC3, "R6 first framed value");
        send_char(8'h5A, 8);
        chk(char_data, 8'h5A, "R6 held level does not reframe");
        chk({7'd0, early_v}, 8'd0, "R6 no mid-char strobe");

        done = 1;
        summary();
    end
endmodule